// File: doc/BRIEF.md
# Mixer-Detector Sampled Phase Tracking Loop

This block is a second-order, sample-driven phase tracking loop for a real sinusoidal input. An internal phase word drives a quadrature synthesizer that yields a cosine and a negated sine of the current phase. The negated sine is multiplied by the incoming sample. The rounded product serves as the phase error: its slow term is (A/2)·sin(input phase − local phase), and a ripple term at twice the carrier rides on top of it. No dedicated low-pass stage removes that ripple. The proportional-plus-integral loop filter averages it out, and its output steers the phase accumulator away from the programmed nominal step.

Each valid input sample advances the loop by exactly one step. One cycle later the block presents the in-phase synthesizer value used for that sample, the error and the filter output. Gains and the nominal step are plain inputs. Choosing the gains and controlling the input amplitude are left to the surrounding system.

Top module: `mix_pll_tracker`

## Requirements
- R1: Synchronous active-high reset clears the phase word, the integrator and all outputs to zero, and `out_valid` to 0. The first sample after reset therefore sees phase 0.
- R2: State changes only in cycles with `in_valid` high, and `in_sample` is ignored otherwise. `out_valid` equals `in_valid` delayed by one cycle, and the data outputs hold their values while no sample arrives.
- R3: The synthesizer takes bin index k from the top 10 bits of the 32-bit phase word (full scale = 2π). `cos_out` = round(32767·cos(2π(k+0.5)/1024)) of the phase used for that sample. The negated sine fed to the detector is round(−32767·sin(2π(k+0.5)/1024)).
- R4: `err_out` = (in_sample·nsin + 2^14) >>> 15 (arithmetic), saturated to the 16-bit signed range.
- R5: The filter output is v = err·k1_gain + I(n), and `ctl_out` = v >>> 16 (arithmetic). With both gains zero, `ctl_out` is 0. With k2_gain = 0, `ctl_out` depends only on the current error.
- R6: The integrator follows I(n) = I(n−1) + err(n)·k2_gain, held in 40 signed bits, and saturates instead of wrapping. The gains are unsigned Q0.16 values.
- R7: The next phase is phase + nom_step + ((v·20861) >>> 16), taken modulo 2^32. With zero gains the phase advances by exactly nom_step per sample.
- R8: With k1_gain = 19386, k2_gain = 773, nom_step = 2^32/10 and a full-scale input cosine offset by π, the mean error over 20 samples after sample 280 lies within ±328, and the synthesized cosine is in phase with the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed Q1.15 input sample |
| k1_gain | input | 16 | Proportional gain, unsigned Q0.16 |
| k2_gain | input | 16 | Integral gain, unsigned Q0.16 |
| nom_step | input | 32 | Nominal phase step per sample (2^32 = 2π) |
| out_valid | output | 1 | Results valid, one cycle after in_valid |
| cos_out | output | 16 | In-phase synthesizer value used for the sample |
| err_out | output | 16 | Rounded, saturated detector product |
| ctl_out | output | 32 | Loop filter output in Q.15 units |

## Verification
The open-loop pattern (zero gains, odd phase step, a sweep of input values) exercises the quadrant folding of the synthesizer and the rounding of the detector, with no feedback to hide an error. The proportional-only and integral-only patterns use a bench-side model of the loop recursion. They tell a wrong gain scaling, a lost sign or a missing integrator memory apart from one another, because the predicted next phase is compared against the synthesizer output. A gapped stream with garbage between samples separates correct strobe gating from state leakage. A run from a π offset shows whether the ripple-laden error is averaged down to a locked, in-phase state.

// File: rtl/mix_pll_pkg.sv
package mix_pll_pkg;

    localparam int SAMPLE_W = 16;
    localparam int GAIN_W   = 16;
    localparam int PHASE_W  = 32;
    localparam int LUT_W    = 10;
    localparam int AMP_W    = 16;
    localparam int INTEG_W  = 40;
    localparam int CTL_W    = 32;

    localparam real PI_R = 3.14159265358979;

    // phase counts per radian of filter output, scaled by 2^16 (v unit is Q.31)
    localparam int RAD_TO_STEP = $rtoi(65536.0 / PI_R + 0.5);

    typedef enum logic [1:0] {Q_I, Q_II, Q_III, Q_IV} quad_e;

    function automatic real taylor_sin(input real a);
        real term;
        real acc;
        term = a;
        acc  = a;
        for (int i = 1; i < 12; i++) begin
            term = -term * a * a / real'((2 * i) * (2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // magnitude of one quarter-wave entry, sampled at the bin centre
    function automatic int quarter_entry(input int r, input int qbits, input int amp);
        real ang;
        ang = (PI_R / 2.0) * (real'(r) + 0.5) / (2.0 ** qbits);
        return $rtoi(real'(amp) * taylor_sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/mix_pll_sincos.sv
module mix_pll_sincos
    import mix_pll_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int LW = LUT_W,
    parameter int AW = AMP_W
) (
    input  logic [PW-1:0]        phase,
    output logic signed [AW-1:0] cos_o,
    output logic signed [AW-1:0] nsin_o
);
    localparam int QW  = LW - 2;
    localparam int QN  = 1 << QW;
    localparam int AMP = (1 << (AW - 1)) - 1;

    logic [AW-1:0] rom [QN];

    for (genvar i = 0; i < QN; i++) begin : g_rom
        localparam int ENTRY = quarter_entry(i, QW, AMP);
        assign rom[i] = ENTRY[AW-1:0];
    end

    logic [LW-1:0] idx;
    quad_e         quad;
    logic [QW-1:0] r_fwd;
    logic signed [AW-1:0] mag_a;
    logic signed [AW-1:0] mag_b;
    logic signed [AW-1:0] sin_v;

    assign idx   = phase[PW-1 -: LW];
    assign quad  = quad_e'(idx[LW-1 -: 2]);
    assign r_fwd = idx[QW-1:0];
    assign mag_a = $signed(rom[r_fwd]);
    assign mag_b = $signed(rom[~r_fwd]);

    always_comb begin
        unique case (quad)
            Q_I:     begin sin_v =  mag_a; cos_o =  mag_b; end
            Q_II:    begin sin_v =  mag_b; cos_o = -mag_a; end
            Q_III:   begin sin_v = -mag_a; cos_o = -mag_b; end
            default: begin sin_v = -mag_b; cos_o =  mag_a; end
        endcase
        nsin_o = -sin_v;
    end

    // R3: the quadrature pair stays on the unit circle within rounding
    localparam longint R2_LO = longint'(AMP - 1) * longint'(AMP - 1);
    localparam longint R2_HI = longint'(AMP + 1) * longint'(AMP + 1);
    always_comb begin
        if (!$isunknown(phase)) begin
            p_unit_circle_r3: assert ((longint'(cos_o) * cos_o + longint'(nsin_o) * nsin_o >= R2_LO) &&
                                      (longint'(cos_o) * cos_o + longint'(nsin_o) * nsin_o <= R2_HI))
                else $error("synthesizer pair off unit circle");
        end
    end

endmodule

// File: rtl/mix_pll_detector.sv
module mix_pll_detector #(
    parameter int XW = 16,
    parameter int AW = 16,
    parameter int EW = 16
) (
    input  logic signed [XW-1:0] x_i,
    input  logic signed [AW-1:0] ys_i,
    output logic signed [EW-1:0] err_o
);
    localparam int PRW = XW + AW;
    localparam logic signed [PRW:0] RND  = (PRW + 1)'(2 ** (AW - 2));
    localparam logic signed [PRW:0] EMAX = (PRW + 1)'(2 ** (EW - 1) - 1);
    localparam logic signed [PRW:0] EMIN = ~EMAX;

    logic signed [PRW-1:0] prod;
    logic signed [PRW:0]   rnd;
    logic signed [PRW:0]   shifted;

    always_comb begin
        prod    = x_i * ys_i;
        rnd     = (PRW + 1)'(prod) + RND;
        shifted = rnd >>> (AW - 1);
        if (shifted > EMAX)      err_o = EMAX[EW-1:0];
        else if (shifted < EMIN) err_o = EMIN[EW-1:0];
        else                     err_o = shifted[EW-1:0];
    end

    // R4: the error keeps the sign of the product
    always_comb begin
        if (!$isunknown({x_i, ys_i})) begin
            p_err_sign_r4: assert (!((x_i >= 0) == (ys_i >= 0)) || err_o >= 0)
                else $error("error sign disagrees with product");
        end
    end

endmodule

// File: rtl/mix_pll_filter.sv
module mix_pll_filter #(
    parameter int EW = 16,
    parameter int KW = 16,
    parameter int IW = 40,
    parameter int VW = IW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [EW-1:0] err_i,
    input  logic [KW-1:0]        k1_i,
    input  logic [KW-1:0]        k2_i,
    output logic signed [VW-1:0] v_o
);
    localparam int PRW = EW + KW + 1;
    localparam logic signed [IW-1:0] IMAX = {1'b0, {(IW - 1){1'b1}}};
    localparam logic signed [IW-1:0] IMIN = {1'b1, {(IW - 1){1'b0}}};

    logic signed [PRW-1:0] prop;
    logic signed [PRW-1:0] inc;
    logic signed [IW:0]    sum;
    logic signed [IW-1:0]  integ;
    logic signed [IW-1:0]  integ_nx;

    always_comb begin
        prop = err_i * $signed({1'b0, k1_i});
        inc  = err_i * $signed({1'b0, k2_i});
        sum  = (IW + 1)'(integ) + (IW + 1)'(inc);
        if (sum > (IW + 1)'(IMAX))      integ_nx = IMAX;
        else if (sum < (IW + 1)'(IMIN)) integ_nx = IMIN;
        else                            integ_nx = sum[IW-1:0];
        v_o = VW'(prop) + VW'(integ_nx);
    end

    always_ff @(posedge clk) begin
        if (rst)     integ <= '0;
        else if (en) integ <= integ_nx;
    end

    p_integ_sat_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (en && integ == IMAX && inc >= 0) |=> integ == IMAX);
    p_integ_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (en && integ == IMIN && inc <= 0) |=> integ == IMIN);
    p_integ_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(integ));

endmodule

// File: rtl/mix_pll_phase_acc.sv
module mix_pll_phase_acc
    import mix_pll_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int VW = INTEG_W + 1,
    parameter int KW = GAIN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [PW-1:0]        step_i,
    input  logic signed [VW-1:0] v_i,
    output logic [PW-1:0]        phase_o
);
    localparam logic signed [17:0] KRAD = 18'(RAD_TO_STEP);

    logic signed [VW+17:0] scaled;
    logic signed [VW+17:0] dph;

    always_comb begin
        scaled = v_i * KRAD;
        dph    = scaled >>> KW;
    end

    always_ff @(posedge clk) begin
        if (rst)     phase_o <= '0;
        else if (en) phase_o <= phase_o + step_i + dph[PW-1:0];
    end

    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_o));

endmodule

// File: rtl/mix_pll_tracker.sv
module mix_pll_tracker
    import mix_pll_pkg::*;
#(
    parameter int XW = SAMPLE_W,
    parameter int KW = GAIN_W,
    parameter int PW = PHASE_W,
    parameter int LW = LUT_W,
    parameter int AW = AMP_W,
    parameter int IW = INTEG_W,
    parameter int OW = CTL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] in_sample,
    input  logic [KW-1:0]        k1_gain,
    input  logic [KW-1:0]        k2_gain,
    input  logic [PW-1:0]        nom_step,
    output logic                 out_valid,
    output logic signed [AW-1:0] cos_out,
    output logic signed [XW-1:0] err_out,
    output logic signed [OW-1:0] ctl_out
);
    localparam int VW = IW + 1;

    logic [PW-1:0]        phase;
    logic signed [AW-1:0] cos_w;
    logic signed [AW-1:0] nsin_w;
    logic signed [XW-1:0] err_w;
    logic signed [VW-1:0] v_w;
    logic signed [VW-1:0] v_sh;

    mix_pll_sincos #(.PW(PW), .LW(LW), .AW(AW)) u_sincos (
        .phase  (phase),
        .cos_o  (cos_w),
        .nsin_o (nsin_w)
    );

    mix_pll_detector #(.XW(XW), .AW(AW), .EW(XW)) u_det (
        .x_i   (in_sample),
        .ys_i  (nsin_w),
        .err_o (err_w)
    );

    mix_pll_filter #(.EW(XW), .KW(KW), .IW(IW), .VW(VW)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .err_i (err_w),
        .k1_i  (k1_gain),
        .k2_i  (k2_gain),
        .v_o   (v_w)
    );

    mix_pll_phase_acc #(.PW(PW), .VW(VW), .KW(KW)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (in_valid),
        .step_i  (nom_step),
        .v_i     (v_w),
        .phase_o (phase)
    );

    assign v_sh = v_w >>> KW;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cos_out   <= '0;
            err_out   <= '0;
            ctl_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cos_out <= cos_w;
                err_out <= err_w;
                ctl_out <= OW'(v_sh);
            end
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(cos_out) && $stable(err_out) && $stable(ctl_out)));

endmodule

// File: tb/mix_pll_tracker_tb.sv
module mix_pll_tracker_tb;

    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic [15:0]        k1_gain = '0;
    logic [15:0]        k2_gain = '0;
    logic [31:0]        nom_step = '0;
    logic               out_valid;
    logic signed [15:0] cos_out;
    logic signed [15:0] err_out;
    logic signed [31:0] ctl_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [31:0] ph_m;
    longint      i_m;

    always #4 clk = ~clk;

    mix_pll_tracker u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .k1_gain   (k1_gain),
        .k2_gain   (k2_gain),
        .nom_step  (nom_step),
        .out_valid (out_valid),
        .cos_out   (cos_out),
        .err_out   (err_out),
        .ctl_out   (ctl_out)
    );

    function automatic int rnd(input real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic real bin_angle(input logic [31:0] ph);
        return 2.0 * PI * (real'(ph[31:22]) + 0.5) / 1024.0;
    endfunction

    function automatic int exp_cos(input logic [31:0] ph);
        return rnd(32767.0 * $cos(bin_angle(ph)));
    endfunction

    function automatic int exp_nsin(input logic [31:0] ph);
        return rnd(-32767.0 * $sin(bin_angle(ph)));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp, input longint tol);
        longint d;
        n_chk++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ph_m = '0;
        i_m  = 0;
    endtask

    task automatic push(input int x);
        in_sample = 16'(x);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    // one closed-loop sample, compared against the requirement equations
    task automatic loop_step(input int x, input string tag);
        longint e;
        longint v;
        push(x);
        chk("R2", {tag, " out_valid"}, longint'(out_valid), 1, 0);
        chk("R7", {tag, " cos from predicted phase"}, cos_out, exp_cos(ph_m), 1);
        e   = err_out;
        i_m = i_m + e * longint'(k2_gain);
        v   = e * longint'(k1_gain) + i_m;
        chk("R5", {tag, " ctl"}, ctl_out, v >>> 16, 0);
        ph_m = ph_m + nom_step + 32'((v * 20861) >>> 16);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "out_valid after reset", longint'(out_valid), 0, 0);
        chk("R1", "cos_out after reset", cos_out, 0, 0);
        chk("R1", "err_out after reset", err_out, 0, 0);
        chk("R1", "ctl_out after reset", ctl_out, 0, 0);
        k1_gain = 0; k2_gain = 0; nom_step = 0;
        push(1000);
        chk("R1", "first sample sees phase 0", cos_out, exp_cos(32'd0), 1);
        chk("R1", "integrator cleared", ctl_out, 0, 0);
    endtask

    task automatic t_open_loop();
        logic [31:0] ph;
        int ys;
        int x;
        do_reset();
        k1_gain = 0; k2_gain = 0; nom_step = 32'h0123_4567;
        ph = '0;
        for (int n = 0; n < 64; n++) begin
            x  = ((n * 7919 + 123) % 65536) - 32768;
            ys = exp_nsin(ph);
            push(x);
            chk("R3", "open-loop cos_out", cos_out, exp_cos(ph), 1);
            chk("R4", "open-loop err_out", err_out, (longint'(x) * ys + 16384) >>> 15, 1);
            chk("R5", "zero gains ctl_out", ctl_out, 0, 0);
            ph = ph + nom_step;  // R7: exact nominal step with zero gains
        end
    endtask

    task automatic t_prop();
        do_reset();
        k1_gain = 16'd40000; k2_gain = 0; nom_step = 32'd613566757;
        for (int n = 0; n < 60; n++)
            loop_step(rnd(30000.0 * $cos(2.0 * PI * n / 7.0 + 1.0)), "R5 proportional");
    endtask

    task automatic t_integ();
        do_reset();
        k1_gain = 0; k2_gain = 16'd3000; nom_step = 32'd536870912;
        for (int n = 0; n < 60; n++)
            loop_step(rnd(25000.0 * $cos(2.0 * PI * n / 8.2 + 2.0)), "R6 integral");
    endtask

    task automatic t_gaps();
        logic signed [15:0] c_hold;
        do_reset();
        k1_gain = 16'd19386; k2_gain = 16'd773; nom_step = 32'd429496730;
        for (int n = 0; n < 30; n++) begin
            loop_step(rnd(32767.0 * $cos(2.0 * PI * n / 10.0 + 0.7)), "R2 gapped");
            c_hold = cos_out;
            for (int g = 0; g < (n % 3) + 1; g++) begin
                in_sample = 16'(n * 977 - 16000);
                @(negedge clk);
                chk("R2", "no out_valid in gap", longint'(out_valid), 0, 0);
                chk("R2", "cos_out held in gap", cos_out, c_hold, 0);
            end
        end
    endtask

    task automatic t_lock();
        longint esum;
        longint csum;
        int x;
        do_reset();
        k1_gain = 16'd19386; k2_gain = 16'd773; nom_step = 32'd429496730;
        esum = 0; csum = 0;
        for (int n = 0; n < 300; n++) begin
            x = rnd(32767.0 * $cos(2.0 * PI * n / 10.0 + PI));
            loop_step(x, "R8 lock run");
            if (n >= 280) begin
                esum += err_out;
                csum += longint'(x) * cos_out;
            end
        end
        chk("R8", "mean error after lock", esum / 20, 0, 328);
        n_chk++;
        if (csum / 20 < 64'sd450000000) begin
            n_fail++;
            $display("FAIL R8 in-phase correlation actual=%0d expected>=450000000", csum / 20);
        end
    endtask

    initial begin
        t_reset();
        t_open_loop();
        t_prop();
        t_integ();
        t_gaps();
        t_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule